// File: doc/BRIEF.md
# Single-Channel Block Copy Engine

This block is one channel of a memory-to-memory copy engine. Software programs a source address, a destination address, a unit count and a 16-bit control word through a small write port. The engine then moves that many units, each a 16-bit halfword or a 32-bit word. It moves each unit as one read from the source followed by one write to the destination, over a request/acknowledge memory bus that carries one access at a time.

Each address steps on its own rule: up, down or held. One destination rule also increments, but the final destination is not stored back, so a repeated run starts again from the programmed place. A run starts in one of two ways: directly from the control write that turns the channel on, or from one of three trigger pulses. Trigger 3 has a special meaning on the channels that feed a sound FIFO. There it forces exactly four word units into a fixed destination. On the lowest channel (CHAN_ID 0) trigger 3 is illegal and starts nothing.

When a run ends, the block stores back the stepped addresses and clears the enable bit unless repeat is set. If the control word asks for it, the block also issues a one-cycle interrupt pulse. Parameters set the source width, the destination width and the count width, so the same module covers the narrow and the wide channels.

Top module: `dma_chan`

## Requirements
- R1: Control bit 10 picks the unit. A 1 selects 32-bit words (`mem_word`=1, address step 4). A 0 selects 16-bit halfwords (`mem_word`=0, address step 2). For halfwords only `mem_wdata[15:0]` carries the unit.
- R2: Control bits [8:7] set the source rule: 0 steps up, 1 steps down, and 2 or 3 hold the address. Addresses wrap at the source width.
- R3: Control bits [6:5] set the destination rule: 0 and 3 step up, 1 steps down, and 2 holds the address. Addresses wrap at the destination width.
- R4: At the end of a run the stepped source address is stored into `src_q`. The stepped destination is stored into `dst_q` unless the destination rule is 3. With rule 3, `dst_q` keeps its programmed value and a repeated run starts from it again.
- R5: A count of zero moves 2^CNT_W units.
- R6: Register select 0 writes the source, 1 the destination, 2 the count and 3 the control word (`reg_wdata[15:0]`). Source, destination and count keep only their low SRC_AW, DST_AW and CNT_W bits.
- R7: Control bit 15 enables the channel and bits [13:12] choose the start. With start 0, the run begins on the control write that turns enable from 0 to 1: `busy` is high after the second rising edge from that write. With start 1, 2 or 3, the run begins on the edge that sees `trig[start-1]` high. A trigger has no effect while the channel is disabled or busy.
- R8: On a FIFO-capable channel (CHAN_ID 1 or 2), start 3 moves exactly 4 word units to a fixed destination, whatever the count, unit bit and destination rule say.
- R9: On CHAN_ID 0, start 3 never starts a run, and the channel stays enabled.
- R10: After the last write, control bit 15 clears unless repeat (bit 9) is set. If bit 14 was set, `irq` is high for exactly one cycle.
- R11: For each unit the read comes before the write. A request holds its address, direction and data until it is acknowledged, and only one access is outstanding.
- R12: `busy` is high from the first read request until the final write is acknowledged, and low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| reg_wdata | input | 32 | Register write data |
| trig | input | 3 | Start pulses for start modes 1, 2, 3 |
| src_q | output | SRC_AW | Source address register |
| dst_q | output | DST_AW | Destination address register |
| cnt_q | output | CNT_W | Count register |
| ctrl_q | output | 16 | Control register |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_word | output | 1 | 1 word, 0 halfword |
| mem_addr | output | max(SRC_AW,DST_AW) | Access address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with ack on reads |
| mem_ack | input | 1 | Access completes on the edge it is high |
| busy | output | 1 | Run in progress |
| irq | output | 1 | One-cycle completion pulse |

## Verification
A trigger pulse seen at an edge raises `busy` and the first read request at that same edge. A start-0 control write raises them one edge later, so the bench samples `busy` low and then high on the two falling edges that follow the write. Each memory access finishes on the edge where the bench's acknowledge is high. The bench checks every address and data value at the falling edge where it grants the access. It reads the stored-back registers, the enable bit and the interrupt count only after `busy` has dropped and two more cycles have passed, by which time the write-back cycle and the interrupt pulse are over.

// File: rtl/dma_chan.sv
module dma_chan #(
  parameter int SRC_AW  = 28,
  parameter int DST_AW  = 27,
  parameter int CNT_W   = 14,
  parameter int CHAN_ID = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [1:0]           reg_sel,
  input  logic [31:0]          reg_wdata,
  input  logic [2:0]           trig,
  output logic [SRC_AW-1:0]    src_q,
  output logic [DST_AW-1:0]    dst_q,
  output logic [CNT_W-1:0]     cnt_q,
  output logic [15:0]          ctrl_q,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic                 mem_word,
  output logic [((SRC_AW > DST_AW) ? SRC_AW : DST_AW)-1:0] mem_addr,
  output logic [31:0]          mem_wdata,
  input  logic [31:0]          mem_rdata,
  input  logic                 mem_ack,
  output logic                 busy,
  output logic                 irq
);
  localparam int MEM_AW   = (SRC_AW > DST_AW) ? SRC_AW : DST_AW;
  localparam int RW       = CNT_W + 1;
  localparam bit FIFO_OK  = (CHAN_ID == 1) || (CHAN_ID == 2);
  localparam bit M3_BAD   = (CHAN_ID == 0);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_DONE} st_t;
  st_t st;

  logic              en, irq_en, rpt, wsz;
  logic [1:0]        smode, sm, dm;
  assign en     = ctrl_q[15];
  assign irq_en = ctrl_q[14];
  assign smode  = ctrl_q[13:12];
  assign wsz    = ctrl_q[10];
  assign rpt    = ctrl_q[9];
  assign sm     = ctrl_q[8:7];
  assign dm     = ctrl_q[6:5];

  logic [SRC_AW-1:0] cur_src, nxt_src;
  logic [DST_AW-1:0] cur_dst, nxt_dst;
  logic [RW-1:0]     remain;
  logic [31:0]       dbuf;
  logic              r_word, r_fifo, r_keep, r_irq, r_rpt, kick;
  logic [1:0]        r_sm, r_dm;
  logic [2:0]        stp;

  logic trig_hit, go, fifo_now, unused_bits;
  assign unused_bits = ^{reg_wdata, ctrl_q[11], ctrl_q[4:0]};

  assign trig_hit = (smode == 2'd1 && trig[0]) ||
                    (smode == 2'd2 && trig[1]) ||
                    (smode == 2'd3 && trig[2] && !M3_BAD);
  assign go       = (st == S_IDLE) && en && ((smode == 2'd0) ? kick : trig_hit);
  assign fifo_now = FIFO_OK && (smode == 2'd3);

  assign stp     = r_word ? 3'd4 : 3'd2;
  assign nxt_src = (r_sm == 2'd0) ? cur_src + SRC_AW'(stp) :
                   (r_sm == 2'd1) ? cur_src - SRC_AW'(stp) : cur_src;
  assign nxt_dst = (r_dm == 2'd2) ? cur_dst :
                   (r_dm == 2'd1) ? cur_dst - DST_AW'(stp) : cur_dst + DST_AW'(stp);

  assign mem_req   = (st == S_RD) || (st == S_WR);
  assign mem_we    = (st == S_WR);
  assign mem_word  = r_word;
  assign mem_addr  = (st == S_WR) ? MEM_AW'(cur_dst) : MEM_AW'(cur_src);
  assign mem_wdata = dbuf;
  assign busy      = mem_req;
  assign irq       = (st == S_DONE) && r_irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
      kick   <= 1'b0;
    end else begin
      if (go || !en) kick <= 1'b0;
      if (reg_we) begin
        case (reg_sel)
          2'd0: src_q  <= reg_wdata[SRC_AW-1:0];
          2'd1: dst_q  <= reg_wdata[DST_AW-1:0];
          2'd2: cnt_q  <= reg_wdata[CNT_W-1:0];
          default: begin
            ctrl_q <= reg_wdata[15:0];
            if (reg_wdata[15] && !en && reg_wdata[13:12] == 2'd0) kick <= 1'b1;
          end
        endcase
      end
      if (st == S_DONE) begin
        src_q <= cur_src;
        if (!r_keep) dst_q <= cur_dst;
        if (!r_rpt) ctrl_q[15] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cur_src <= '0;
      cur_dst <= '0;
      remain  <= '0;
      dbuf    <= '0;
      r_word  <= 1'b0;
      r_fifo  <= 1'b0;
      r_keep  <= 1'b0;
      r_irq   <= 1'b0;
      r_rpt   <= 1'b0;
      r_sm    <= '0;
      r_dm    <= '0;
    end else begin
      case (st)
        S_IDLE: if (go) begin
          cur_src <= src_q;
          cur_dst <= dst_q;
          r_word  <= fifo_now | wsz;
          r_fifo  <= fifo_now;
          r_sm    <= sm;
          r_dm    <= fifo_now ? 2'd2 : dm;
          r_keep  <= (dm == 2'd3);
          r_irq   <= irq_en;
          r_rpt   <= rpt;
          if (fifo_now)          remain <= RW'(4);
          else if (cnt_q == '0)  remain <= RW'(1) << CNT_W;
          else                   remain <= {1'b0, cnt_q};
          st <= S_RD;
        end
        S_RD: if (mem_ack) begin
          dbuf    <= mem_rdata;
          cur_src <= nxt_src;
          st      <= S_WR;
        end
        S_WR: if (mem_ack) begin
          cur_dst <= nxt_dst;
          remain  <= remain - RW'(1);
          st      <= (remain == RW'(1)) ? S_DONE : S_RD;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R11
  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_ack |=> mem_req && mem_we); // R11
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(mem_ack && mem_we)); // R12
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R10
  AST_FIFO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && r_fifo |-> mem_word); // R8
  AST_FIFO_DST: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ack && r_fifo |=> $stable(cur_dst)); // R8
  AST_NO_M3_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    M3_BAD && !busy && smode == 2'd3 && ctrl_q[15] |=> !busy); // R9
  AST_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> remain != '0); // R5
endmodule

// File: tb/dma_chan_bench.sv
module dma_chan_bench;
  localparam int SAW = 28, DAW = 27, CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        reg_we = 1'b0, reg_we_lo = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [2:0]  trig = '0;
  logic [SAW-1:0] src_q;
  logic [DAW-1:0] dst_q;
  logic [CW-1:0]  cnt_q;
  logic [15:0]    ctrl_q;
  logic mem_req, mem_we, mem_word, busy, irq;
  logic [SAW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic mem_ack = 1'b0;

  logic [SAW-1:0] lo_src; logic [DAW-1:0] lo_dst; logic [CW-1:0] lo_cnt; logic [15:0] lo_ctrl;
  logic lo_req, lo_we, lo_word, lo_busy, lo_irq;
  logic [SAW-1:0] lo_addr; logic [31:0] lo_wdata;
  logic lo_ack = 1'b0;

  dma_chan #(.SRC_AW(SAW), .DST_AW(DAW), .CNT_W(CW), .CHAN_ID(1)) u_dma_chan (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .trig(trig), .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q), .ctrl_q(ctrl_q),
    .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack), .busy(busy), .irq(irq));

  dma_chan #(.SRC_AW(SAW), .DST_AW(DAW), .CNT_W(CW), .CHAN_ID(0)) u_dma_chan_low (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we_lo), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .trig(trig), .src_q(lo_src), .dst_q(lo_dst), .cnt_q(lo_cnt), .ctrl_q(lo_ctrl),
    .mem_req(lo_req), .mem_we(lo_we), .mem_word(lo_word), .mem_addr(lo_addr),
    .mem_wdata(lo_wdata), .mem_rdata(32'h0), .mem_ack(lo_ack), .busy(lo_busy), .irq(lo_irq));

  int total = 0, bad = 0;
  int wr_seen = 0, rd_bad = 0, wr_bad = 0, irq_cnt = 0, acc_cnt = 0, wt = 0, lo_seen = 0;
  logic [31:0] exp_s, exp_d, pend_s, g_dst0;
  int skind, dkind, g_n, g_dm;
  bit exp_w;

  function automatic logic [31:0] rdv(logic [31:0] a);
    return (a ^ (a << 5)) ^ 32'h9E37_79B9;
  endfunction

  function automatic logic [31:0] nxt(logic [31:0] a, int kind, bit w, int aw);
    logic [31:0] d, r;
    d = w ? 32'd4 : 32'd2;
    case (kind)
      0: r = a + d;
      1: r = a - d;
      default: r = a;
    endcase
    return r & (32'hFFFF_FFFF >> (32 - aw));
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (lo_req) lo_seen++;
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (wt > 0) wt--;
      else begin
        mem_ack = 1'b1;
        wt = $urandom % 3;
        acc_cnt++;
        if (!mem_we) begin
          mem_rdata = rdv({4'h0, mem_addr});
          if (mem_addr != exp_s[SAW-1:0] || mem_word != exp_w) rd_bad++;
          pend_s = exp_s;
          exp_s = nxt(exp_s, skind, exp_w, SAW);
        end else begin
          wr_seen++;
          if (mem_addr[DAW-1:0] != exp_d[DAW-1:0] || mem_word != exp_w ||
              (exp_w ? (mem_wdata != rdv(pend_s)) : (mem_wdata[15:0] != rdv(pend_s)[15:0])))
            wr_bad++;
          exp_d = nxt(exp_d, dkind, exp_w, DAW);
        end
      end
    end
  end

  task automatic wr_reg(bit lo, logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    if (lo) reg_we_lo = 1'b1; else reg_we = 1'b1;
    reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_we_lo = 1'b0;
  endtask

  task automatic pulse(int m);
    @(negedge clk);
    trig[m-1] = 1'b1;
    @(negedge clk);
    trig = '0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic run(logic [31:0] src, logic [31:0] dst, logic [31:0] cnt, bit w, bit rpt,
                     bit irqe, int mode, int sm, int dm);
    logic [15:0] c;
    bit fifo;
    logic [31:0] cm;
    wr_reg(0, 2'd3, 32'h0);
    fifo  = (mode == 3);
    cm    = cnt & ((32'd1 << CW) - 1);
    exp_s = src & (32'hFFFF_FFFF >> (32 - SAW));
    exp_d = dst & (32'hFFFF_FFFF >> (32 - DAW));
    g_dst0 = exp_d; g_dm = dm;
    exp_w = fifo | w;
    skind = (sm < 2) ? sm : 2;
    dkind = fifo ? 2 : (dm == 2 ? 2 : (dm == 1 ? 1 : 0));
    g_n   = fifo ? 4 : (cm == 0 ? (1 << CW) : int'(cm));
    wr_seen = 0; rd_bad = 0; wr_bad = 0; irq_cnt = 0;
    c = {1'b1, irqe, mode[1:0], 1'b0, w, rpt, sm[1:0], dm[1:0], 5'b0};
    wr_reg(0, 2'd0, src);
    wr_reg(0, 2'd1, dst);
    wr_reg(0, 2'd2, cnt);
    chk(src_q == exp_s[SAW-1:0] && dst_q == exp_d[DAW-1:0] && cnt_q == cm[CW-1:0],
        "R6 masked regs", {src_q, dst_q}, {exp_s[SAW-1:0], exp_d[DAW-1:0]});
    wr_reg(0, 2'd3, {16'h0, c});
    if (mode == 0) begin
      chk(busy == 1'b0, "R7 start0 not yet", busy, 0);
      @(negedge clk);
      chk(busy == 1'b1, "R12 busy after start0", busy, 1);
    end else begin
      pulse(mode);
      chk(busy == 1'b1, "R7 trigger start", busy, 1);
    end
    wait_idle();
    chk(wr_seen == g_n, "R5 R8 unit count", wr_seen, g_n);
    chk(rd_bad == 0, "R2 R1 R11 read sequence", rd_bad, 0);
    chk(wr_bad == 0, "R3 R1 R11 write sequence", wr_bad, 0);
    chk(src_q == exp_s[SAW-1:0], "R4 src writeback", src_q, exp_s[SAW-1:0]);
    chk(dst_q == (dm == 3 ? g_dst0[DAW-1:0] : exp_d[DAW-1:0]), "R4 dst writeback", dst_q,
        dm == 3 ? g_dst0[DAW-1:0] : exp_d[DAW-1:0]);
    chk(ctrl_q[15] == rpt, "R10 enable after run", ctrl_q[15], rpt);
    chk(irq_cnt == int'(irqe), "R10 irq pulse", irq_cnt, irqe);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int a0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(src_q == 0 && dst_q == 0 && cnt_q == 0 && ctrl_q == 0, "R6 reset regs", ctrl_q, 0);
    chk(!busy && !mem_req && !irq, "R12 reset idle", {busy, mem_req, irq}, 0);

    // R6 masking
    wr_reg(0, 2'd0, 32'hFFFF_FFFF);
    wr_reg(0, 2'd2, 32'h0000_1234);
    chk(src_q == 28'hFFF_FFFF, "R6 src mask", src_q, 28'hFFF_FFFF);
    chk(cnt_q == 8'h34, "R6 cnt mask", cnt_q, 8'h34);

    // R7 trigger ignored while disabled
    wr_reg(0, 2'd3, 32'h0000_1000);
    a0 = acc_cnt;
    pulse(1);
    repeat (4) @(negedge clk);
    chk(!busy && acc_cnt == a0, "R7 trigger while disabled", acc_cnt - a0, 0);

    // directed cases
    run(32'h0000_1000, 32'h0200_0000, 3, 1, 0, 1, 0, 0, 0);
    run(32'h0000_0002, 32'h0000_0000, 5, 0, 0, 0, 1, 1, 1);   // wrap down
    run(32'h0800_0000, 32'h0400_0010, 6, 1, 0, 1, 2, 2, 2);
    run(32'h0000_4000, 32'h0000_8000, 0, 0, 0, 0, 0, 3, 0);   // R5 zero count
    run(32'h0000_2000, 32'h0000_0100, 32'h25, 0, 0, 1, 3, 0, 0); // R8 FIFO
    wr_reg(0, 2'd3, 32'h0);

    // R4 rule 3 with repeat, second trigger restarts from original destination
    run(32'h0000_3000, 32'h0000_5000, 4, 1, 1, 0, 1, 0, 3);
    exp_d = g_dst0; wr_seen = 0; wr_bad = 0; rd_bad = 0;
    pulse(1);
    wait_idle();
    chk(wr_seen == g_n && wr_bad == 0 && rd_bad == 0, "R4 repeat restarts dst", wr_bad, 0);
    chk(dst_q == g_dst0[DAW-1:0], "R4 dst kept on repeat", dst_q, g_dst0[DAW-1:0]);
    chk(src_q == exp_s[SAW-1:0], "R4 src continues", src_q, exp_s[SAW-1:0]);
    wr_reg(0, 2'd3, 32'h0);

    // R9 start 3 illegal on lowest channel
    wr_reg(1, 2'd2, 32'd3);
    wr_reg(1, 2'd3, 32'h0000_B400);
    lo_seen = 0;
    pulse(3);
    repeat (6) @(negedge clk);
    chk(lo_seen == 0 && !lo_busy, "R9 no run on lowest channel", lo_seen, 0);
    chk(lo_ctrl[15] == 1'b1, "R9 enable kept", lo_ctrl[15], 1);

    // constrained random
    for (int i = 0; i < 30; i++) begin
      run($urandom, $urandom, 1 + ($urandom % 12), 1'($urandom % 2), 1'($urandom % 2),
          1'($urandom % 2), $urandom % 3, $urandom % 4, $urandom % 4);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule